// File: doc/BRIEF.md
# Register-pair 64-bit extension unit

This block holds a general-purpose register file in which every register is a pair of halves: a low half that ordinary 32-bit code sees, and a high half that only 64-bit code uses. Switching the mode input between 32-bit and 64-bit never clears the high halves, so each one keeps whatever it last held. An execute stage accepts one 16-bit opcode per cycle, with a valid strobe. It carries out a small set of single-register extension operations on the pairs: 4-bit shifts, whole-half shifts, zero and sign extension, a half exchange, and moves between the high half of R0 and another register.

Each accepted operation reads the register selected by opcode bits 11:8 and writes its result back at the next clock edge. Most of the operations are legal only in 64-bit mode. Issuing one of them in 32-bit mode writes nothing and raises an illegal-instruction pulse. An opcode outside the set writes nothing and raises a not-handled pulse instead.

The rest of the core writes base-instruction results into the file through a load port. It reads the file through a combinational read port.

Top module: `regpair_ext_unit`

## Requirements
- R1: After reset every register pair holds zero in both halves, and both status pulses (`illegal_o`, `unhandled_o`) are low.
- R2: In 64-bit mode (`mode64`=1), opcode 0x4n34 shifts the whole 64-bit pair {high,low} of register n left by 4, and 0x4n35 shifts it right logically by 4. Bits move across the boundary between the halves.
- R3: In 32-bit mode, 0x4n34 and 0x4n35 shift only the low half by 4 (left and right logical respectively), and the high half of register n is left unchanged.
- R4: In 64-bit mode, 0x4n38 moves the low half into the high half and clears the low half (left shift by 32). 0x4n39 moves the high half into the low half and clears the high half (right shift by 32).
- R5: In 64-bit mode, 0x4n44 clears the high half (zero extension of the low half). 0x4n54 fills the high half with bit 31 of the low half (sign extension). The low half is unchanged by both.
- R6: In 64-bit mode, 0x4n14 exchanges the high and low halves of register n.
- R7: In 64-bit mode, 0x4n45 copies R0's high half into register n's high half, and 0x4n55 copies register n's high half into R0's high half. All low halves are unchanged.
- R8: An opcode from R2 to R7 other than 0x4n34 and 0x4n35, received with `mode64`=0, writes no register and drives `illegal_o` high for exactly the following cycle.
- R9: Any opcode not listed in R2 to R7 writes no register and drives `unhandled_o` high for exactly the following cycle. `illegal_o` and `unhandled_o` are never high together.
- R10: High halves keep their values across changes of `mode64` and across 32-bit-mode operations.
- R11: A load (`ld_en`=1) writes {`ld_hi`,`ld_lo`} into register `ld_sel`. If a legal operation writes the same register in the same cycle, the operation's result wins and uses the register's value from before that cycle.
- R12: Every operation completes in one cycle. Its result is visible on `rd_lo`/`rd_hi` right after the clock edge that samples the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 16 | Extension opcode, register index in bits 11:8 |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| ld_en | input | 1 | Load port write enable |
| ld_sel | input | 4 | Load port register index |
| ld_lo | input | 32 | Load value, low half |
| ld_hi | input | 32 | Load value, high half |
| rd_sel | input | 4 | Read port register index |
| rd_lo | output | 32 | Low half of the selected register |
| rd_hi | output | 32 | High half of the selected register |
| illegal_o | output | 1 | Pulse: 64-bit-only opcode issued in 32-bit mode |
| unhandled_o | output | 1 | Pulse: opcode not recognised |

## Verification
The bench builds the unit with its default parameters: 32-bit halves and sixteen registers. With these values the opcode's 4-bit register field reaches every register, including R15, and the 0x4n45/0x4n55 moves can use R0 both as source and as destination. Because each half is 32 bits wide, the half shifts and half exchange move real bit patterns across the boundary between the halves. The sign-extension case is checked with the low half's top bit both set and clear. The load-collision case and the 32-bit-mode illegal cases are also reachable with these values.

// File: rtl/regpair_pkg.sv
package regpair_pkg;

    typedef enum logic [3:0] {
        K_NONE,
        K_SHL4,
        K_SHR4,
        K_SHL_HALF,
        K_SHR_HALF,
        K_ZEXT,
        K_SEXT,
        K_SWAP,
        K_HI_FROM_R0,
        K_HI_TO_R0
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic       only64;
        logic [3:0] reg_n;
    } dec_t;

endpackage

// File: rtl/regpair_decode.sv
module regpair_decode
    import regpair_pkg::*;
(
    input  logic [15:0] opcode,
    output dec_t        dec
);
    always_comb begin
        dec.kind   = K_NONE;
        dec.only64 = 1'b1;
        dec.reg_n  = opcode[11:8];
        if (opcode[15:12] == 4'h4) begin
            case (opcode[7:0])
                8'h34:   begin dec.kind = K_SHL4; dec.only64 = 1'b0; end
                8'h35:   begin dec.kind = K_SHR4; dec.only64 = 1'b0; end
                8'h38:   dec.kind = K_SHL_HALF;
                8'h39:   dec.kind = K_SHR_HALF;
                8'h44:   dec.kind = K_ZEXT;
                8'h54:   dec.kind = K_SEXT;
                8'h14:   dec.kind = K_SWAP;
                8'h45:   dec.kind = K_HI_FROM_R0;
                8'h55:   dec.kind = K_HI_TO_R0;
                default: dec.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/regpair_alu.sv
module regpair_alu
    import regpair_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  op_kind_e          kind,
    input  logic              mode64,
    input  logic [HALF_W-1:0] rn_lo,
    input  logic [HALF_W-1:0] rn_hi,
    input  logic [HALF_W-1:0] r0_lo,
    input  logic [HALF_W-1:0] r0_hi,
    output logic              dst_is_r0,
    output logic [HALF_W-1:0] res_lo,
    output logic [HALF_W-1:0] res_hi
);
    localparam int PAIR_W  = 2 * HALF_W;
    localparam int NIB_SH  = 4;

    logic [PAIR_W-1:0] pair;
    assign pair = {rn_hi, rn_lo};

    always_comb begin
        dst_is_r0 = 1'b0;
        res_lo    = rn_lo;
        res_hi    = rn_hi;
        case (kind)
            K_SHL4: begin
                if (mode64) {res_hi, res_lo} = pair << NIB_SH;
                else        res_lo = rn_lo << NIB_SH;
            end
            K_SHR4: begin
                if (mode64) {res_hi, res_lo} = pair >> NIB_SH;
                else        res_lo = rn_lo >> NIB_SH;
            end
            K_SHL_HALF: begin
                res_hi = rn_lo;
                res_lo = '0;
            end
            K_SHR_HALF: begin
                res_lo = rn_hi;
                res_hi = '0;
            end
            K_ZEXT:       res_hi = '0;
            K_SEXT:       res_hi = {HALF_W{rn_lo[HALF_W-1]}};
            K_SWAP: begin
                res_hi = rn_lo;
                res_lo = rn_hi;
            end
            K_HI_FROM_R0: res_hi = r0_hi;
            K_HI_TO_R0: begin
                dst_is_r0 = 1'b1;
                res_lo    = r0_lo;
                res_hi    = rn_hi;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/regpair_ext_unit.sv
module regpair_ext_unit
    import regpair_pkg::*;
#(
    parameter int HALF_W  = 32,
    parameter int REG_CNT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_valid,
    input  logic [15:0]                op_code,
    input  logic                       mode64,
    input  logic                       ld_en,
    input  logic [$clog2(REG_CNT)-1:0] ld_sel,
    input  logic [HALF_W-1:0]          ld_lo,
    input  logic [HALF_W-1:0]          ld_hi,
    input  logic [$clog2(REG_CNT)-1:0] rd_sel,
    output logic [HALF_W-1:0]          rd_lo,
    output logic [HALF_W-1:0]          rd_hi,
    output logic                       illegal_o,
    output logic                       unhandled_o
);
    localparam int IDX_W  = $clog2(REG_CNT);
    localparam int PAIR_W = 2 * HALF_W;

    initial begin
        assert (REG_CNT == 16) else $error("opcode register field needs REG_CNT of 16");
    end

    typedef struct packed {
        logic [REG_CNT-1:0][PAIR_W-1:0] regs;
        logic                           illegal;
        logic                           unhandled;
    } state_t;

    state_t st_d, st_q;

    dec_t              dec;
    logic [IDX_W-1:0]  rn_idx;
    logic [HALF_W-1:0] rn_lo, rn_hi, r0_lo, r0_hi;
    logic [HALF_W-1:0] res_lo, res_hi;
    logic              dst_is_r0;
    logic [IDX_W-1:0]  dst_idx;

    regpair_decode u_decode (
        .opcode (op_code),
        .dec    (dec)
    );

    assign rn_idx = dec.reg_n;
    assign {rn_hi, rn_lo} = st_q.regs[rn_idx];
    assign {r0_hi, r0_lo} = st_q.regs[0];

    regpair_alu #(.HALF_W(HALF_W)) u_alu (
        .kind      (dec.kind),
        .mode64    (mode64),
        .rn_lo     (rn_lo),
        .rn_hi     (rn_hi),
        .r0_lo     (r0_lo),
        .r0_hi     (r0_hi),
        .dst_is_r0 (dst_is_r0),
        .res_lo    (res_lo),
        .res_hi    (res_hi)
    );

    assign dst_idx = dst_is_r0 ? '0 : rn_idx;

    always_comb begin
        st_d           = st_q;
        st_d.illegal   = 1'b0;
        st_d.unhandled = 1'b0;
        if (ld_en) st_d.regs[ld_sel] = {ld_hi, ld_lo};
        if (op_valid) begin
            if (dec.kind == K_NONE)          st_d.unhandled = 1'b1;
            else if (dec.only64 && !mode64)  st_d.illegal   = 1'b1;
            else                             st_d.regs[dst_idx] = {res_hi, res_lo};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign {rd_hi, rd_lo} = st_q.regs[rd_sel];
    assign illegal_o      = st_q.illegal;
    assign unhandled_o    = st_q.unhandled;

    // R8: 64-bit-only op in 32-bit mode touches nothing and pulses illegal
    p_illegal_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dec.kind != K_NONE && dec.only64 && !mode64 && !ld_en)
        |=> ($stable(st_q.regs) && illegal_o));

    // R9: unknown opcode touches nothing and pulses not-handled
    p_unknown_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dec.kind == K_NONE && !ld_en)
        |=> ($stable(st_q.regs) && unhandled_o));

    // R9: the two status pulses are exclusive
    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal_o && unhandled_o));

    // R3: 32-bit-mode nibble shifts keep the high half
    p_hi_kept_32_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !mode64 && (dec.kind == K_SHL4 || dec.kind == K_SHR4))
        |=> (st_q.regs[$past(rn_idx)][PAIR_W-1:HALF_W] == $past(rn_hi)));

    // R6: the half exchange swaps the two halves in one cycle
    p_swap_halves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && mode64 && dec.kind == K_SWAP)
        |=> (st_q.regs[$past(rn_idx)] == {$past(rn_lo), $past(rn_hi)}));

    // R8: illegal pulse only follows a strobed opcode
    p_illegal_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal_o) |-> $past(op_valid && !mode64));
endmodule

// File: tb/regpair_ext_unit_tb_top.sv
module regpair_ext_unit_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] op_code = '0;
    logic        mode64 = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_sel = '0;
    logic [31:0] ld_lo = '0, ld_hi = '0;
    logic [3:0]  rd_sel = '0;
    logic [31:0] rd_lo, rd_hi;
    logic        illegal_o, unhandled_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [31:0] m_lo [16];
    logic [31:0] m_hi [16];

    typedef struct {
        logic [3:0]  sel;
        logic [31:0] lo;
        logic [31:0] hi;
        bit          chk_flags;
        bit          ill;
        bit          unh;
        string       tag;
    } item_t;

    item_t q[$];

    always #(CLK_P/2) clk = ~clk;

    regpair_ext_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .mode64(mode64), .ld_en(ld_en), .ld_sel(ld_sel), .ld_lo(ld_lo),
        .ld_hi(ld_hi), .rd_sel(rd_sel), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .illegal_o(illegal_o), .unhandled_o(unhandled_o)
    );

    // monitor: pops one expected item per falling edge
    always @(negedge clk) begin
        if (q.size() != 0) begin
            item_t it;
            it = q.pop_front();
            rd_sel = it.sel;
            #1;
            n_tests++;
            if (rd_lo !== it.lo || rd_hi !== it.hi) begin
                n_fail++;
                $display("FAIL %s R%0d act %h_%h exp %h_%h", it.tag, it.sel,
                         rd_hi, rd_lo, it.hi, it.lo);
            end
            if (it.chk_flags) begin
                n_tests++;
                if (illegal_o !== it.ill || unhandled_o !== it.unh) begin
                    n_fail++;
                    $display("FAIL %s flags act ill=%b unh=%b exp ill=%b unh=%b",
                             it.tag, illegal_o, unhandled_o, it.ill, it.unh);
                end
            end
        end
    end

    task automatic push_reg(input logic [3:0] sel, input bit cf, input bit ill,
                            input bit unh, input string tag);
        item_t it;
        it.sel = sel; it.lo = m_lo[sel]; it.hi = m_hi[sel];
        it.chk_flags = cf; it.ill = ill; it.unh = unh; it.tag = tag;
        q.push_back(it);
    endtask

    // drive one cycle: optional load, optional opcode; model the expected state
    task automatic drive(input bit do_op, input logic [15:0] oc, input bit m64,
                         input bit do_ld, input logic [3:0] lsel,
                         input logic [31:0] lhi, input logic [31:0] llo,
                         input string tag);
        logic [3:0]  n, dst;
        logic [31:0] lo, hi, nlo, nhi;
        logic [63:0] pr;
        bit ill, unh, wr;
        wait (q.size() == 0);
        @(negedge clk);
        n = oc[11:8]; dst = n; lo = m_lo[n]; hi = m_hi[n];
        nlo = lo; nhi = hi; pr = {hi, lo};
        ill = 0; unh = 0; wr = 0;
        if (do_op) begin
            if (oc[15:12] != 4'h4) unh = 1;
            else begin
                case (oc[7:0])
                    8'h34: begin wr = 1; if (m64) {nhi, nlo} = pr << 4; else nlo = lo << 4; end
                    8'h35: begin wr = 1; if (m64) {nhi, nlo} = pr >> 4; else nlo = lo >> 4; end
                    8'h38: begin wr = 1; nhi = lo; nlo = '0; end
                    8'h39: begin wr = 1; nlo = hi; nhi = '0; end
                    8'h44: begin wr = 1; nhi = '0; end
                    8'h54: begin wr = 1; nhi = {32{lo[31]}}; end
                    8'h14: begin wr = 1; nhi = lo; nlo = hi; end
                    8'h45: begin wr = 1; nhi = m_hi[0]; end
                    8'h55: begin wr = 1; dst = 4'd0; nlo = m_lo[0]; nhi = hi; end
                    default: unh = 1;
                endcase
                if (wr && !m64 && oc[7:0] != 8'h34 && oc[7:0] != 8'h35) begin
                    ill = 1; wr = 0;
                end
            end
        end
        if (do_ld && !(wr && lsel == dst)) begin
            m_lo[lsel] = llo; m_hi[lsel] = lhi;
        end
        if (wr) begin
            m_lo[dst] = nlo; m_hi[dst] = nhi;
        end
        op_valid = do_op; op_code = oc; mode64 = m64;
        ld_en = do_ld; ld_sel = lsel; ld_hi = lhi; ld_lo = llo;
        @(posedge clk);
        #1;
        op_valid = 0; ld_en = 0;
        push_reg(do_op ? dst : lsel, 1, ill, unh, tag);
    endtask

    task automatic op(input logic [15:0] oc, input bit m64, input string tag);
        drive(1, oc, m64, 0, 4'd0, '0, '0, tag);
    endtask

    task automatic load(input logic [3:0] s, input logic [31:0] h, input logic [31:0] l);
        drive(0, 16'h0000, 1'b1, 1, s, h, l, "R11 load");
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        push_reg(4'd0, 1, 0, 0, "R1 reset R0");
        push_reg(4'd15, 0, 0, 0, "R1 reset R15");

        load(4'd3, 32'h01234567, 32'h89ABCDEF);
        load(4'd0, 32'hCAFEF00D, 32'h00000011);
        load(4'd5, 32'h00000000, 32'h80000001);
        load(4'd7, 32'h11112222, 32'h33334444);

        // R2, R12: 64-bit nibble shifts across the half boundary
        op(16'h4334, 1, "R2 R12 shl4 64");
        op(16'h4335, 1, "R2 shr4 64");
        // R3: 32-bit nibble shifts keep high half
        op(16'h4334, 0, "R3 shl4 32");
        op(16'h4335, 0, "R3 shr4 32");
        // R10: high halves persist across mode changes
        push_reg(4'd0, 0, 0, 0, "R10 R0 hi kept");
        op(16'h4F34, 1, "R10 R15 back to 64");
        push_reg(4'd3, 0, 0, 0, "R10 R3 hi kept");
        // R4: half shifts
        op(16'h4338, 1, "R4 shl32");
        op(16'h4339, 1, "R4 shr32");
        // R5: extension, sign bit set and clear
        op(16'h4554, 1, "R5 sext neg");
        op(16'h4544, 1, "R5 zext");
        op(16'h4754, 1, "R5 sext pos");
        // R6: half exchange
        op(16'h4714, 1, "R6 swap");
        // R7: high-half moves
        op(16'h4745, 1, "R7 hi from R0");
        op(16'h4355, 1, "R7 hi to R0");
        push_reg(4'd3, 0, 0, 0, "R7 src R3 kept");
        // R8: 64-bit-only ops in 32-bit mode
        op(16'h4314, 0, "R8 swap in 32");
        op(16'h4738, 0, "R8 shl32 in 32");
        op(16'h4055, 0, "R8 hi-to-R0 in 32");
        // R9: unknown opcodes
        op(16'h1234, 1, "R9 unknown top");
        op(16'h4399, 1, "R9 unknown low");
        op(16'h4336, 0, "R9 unknown near");
        push_reg(4'd3, 1, 0, 0, "R9 pulse ends");
        // R11: load collision and parallel load
        drive(1, 16'h4334, 1, 1, 4'd3, 32'hDEADBEEF, 32'h0BADF00D, "R11 op wins");
        drive(1, 16'h4314, 1, 1, 4'd9, 32'h0000AAAA, 32'h5555FFFF, "R11 op with load");
        push_reg(4'd9, 0, 0, 0, "R11 parallel load");

        wait (q.size() == 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule